// File: doc/BRIEF.md
# Key-Protected System Control Register Bank

A memory-mapped slave that holds a small bank of system-control registers on a plain 32-bit bus. The bus has a byte address, a single-cycle write strobe, write data and a combinational read-data return. The bank contains:

- a fixed identification word;
- an analog-test switch word whose writes only land when the top byte carries an unlock code;
- a temperature-sensor select word;
- a comparator configuration and status word;
- a constant device identity;
- a fully writable part identity.

The comparator word has three inputs to the logic around it: a raw comparator output that arrives asynchronously, is synchronized, and can be read back. When that synchronized output makes an edge of a software-chosen direction, a sticky event flag is set. Software clears the flag by writing zero to its bit. Two outputs follow from it. An event output is raised when the flag is set and event generation is enabled. A wake output follows the synchronized comparator level when wake is enabled.

Top module: `sysctl_regbank`

## Requirements
- R1: Offset 0x000 reads 0x6B4E0010 with default parameters, built as module ID [31:16], standard-block offset [15:12], instance [11:8], major revision [7:4], minor revision [3:0]. Writes to it have no effect.
- R2: After reset, 0x100 reads 0x0000000F, and 0x108, 0x10C and 0x7F8 read 0.
- R3: A write to 0x100 whose bits [31:24] equal 0x5A loads bits [8:0] into the register, and `atest_sw_o` shows them from the next cycle.
- R4: A write to 0x100 with any other value in bits [31:24] leaves the register and `atest_sw_o` unchanged.
- R5: Reads of 0x100 return zero in bits [31:9], including the unlock byte.
- R6: At 0x108, bits [1:0] (select) and [11:8] (spare) are read/write and all other bits read 0. `tsens_on_o` is 0 exactly when select equals 3.
- R7: At 0x10C, bits 30, 29:28, 21, 18, 17, 16 and 14:0 are read/write. Bits 31, 27:25, 23:22, 19 and 15 read 0.
- R8: Bit 20 of 0x10C reads the comparator input after two register stages. A change made just before clock edge k is visible after edge k+1 and not after edge k.
- R9: Bit 24 of 0x10C (event flag) is set on the third clock edge after an input change, when the synchronized level rises and bit 16 is 0, or falls and bit 16 is 1. An edge of the other direction does not set it.
- R10: The event flag stays set until a write to 0x10C with bit 24 equal to 0 clears it. Writing 1 to bit 24 neither sets nor clears it.
- R11: When a qualifying edge and a clearing write meet in the same cycle, the flag ends up set.
- R12: `cmp_event_o` equals bit 17 AND the event flag. `cmp_wake_o` equals bit 18 AND the synchronized comparator level.
- R13: Offset 0x7F8 is a full 32-bit read/write register. Offset 0x3FC reads the device-ID parameter with bit 0 forced to 1 (0x0BB8402F by default) and ignores writes.
- R14: Any other address reads 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (12) | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| cmp_async_i | input | 1 | Raw comparator output, asynchronous |
| atest_sw_o | output | 9 | Analog-test switch controls (bits [8:0] of 0x100) |
| tsens_sel_o | output | 2 | Temperature-sensor select field |
| tsens_on_o | output | 1 | Sensor enabled (select not equal to 3) |
| cmp_event_o | output | 1 | Comparator event request |
| cmp_wake_o | output | 1 | Comparator wake request |

## Verification
A wrong internal state shows up at the ports in one of two ways.

A corrupted or wrongly unlocked register word shows on `bus_rdata` in the cycle the address is presented. It also shows on `atest_sw_o` or `tsens_on_o` one cycle after the faulty write. A synchronizer or edge-detector fault shifts the status bit 20 or the event flag away from the second or third edge after an input change. Because of that, the bench samples both just before and just after those edges.

A lost or spurious event flag shows at once on `cmp_event_o` when event generation is enabled. It stays visible until a clearing write, because the flag is sticky.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
    localparam int unsigned WORD_W = 32;

    // register offsets (byte addresses)
    localparam logic [11:0] OFF_IDENT = 12'h000;
    localparam logic [11:0] OFF_ATEST = 12'h100;
    localparam logic [11:0] OFF_SENS  = 12'h108;
    localparam logic [11:0] OFF_CMP   = 12'h10C;
    localparam logic [11:0] OFF_DEVID = 12'h3FC;
    localparam logic [11:0] OFF_PART  = 12'h7F8;

    // unlock code for the analog-test word
    localparam int unsigned KEY_W     = 8;
    localparam logic [KEY_W-1:0] UNLOCK_CODE = 8'h5A;
    localparam int unsigned ATEST_W   = 9;
    localparam logic [ATEST_W-1:0] ATEST_RST = 9'h00F;

    // comparator word layout
    localparam logic [WORD_W-1:0] CMP_RW_MASK = 32'h7027_7FFF;
    localparam int unsigned CMP_FLAG_BIT  = 24;
    localparam int unsigned CMP_LVL_BIT   = 20;
    localparam int unsigned CMP_WAKE_BIT  = 18;
    localparam int unsigned CMP_EVEN_BIT  = 17;
    localparam int unsigned CMP_FALL_BIT  = 16;

    localparam logic [1:0] SENS_OFF_CODE = 2'd3;

    typedef struct packed {
        logic [1:0]        sens_sel;
        logic [3:0]        sens_spare;
        logic [WORD_W-1:0] cmp_cfg;
        logic [WORD_W-1:0] part_id;
    } bank_t;
endpackage

// File: rtl/sysctl_sync.sv
module sysctl_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = async_i;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], async_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/sysctl_evtflag.sv
module sysctl_evtflag (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    input  logic fall_sel_i,
    input  logic clr_i,
    output logic flag_o
);
    typedef struct packed {
        logic prev;
        logic flag;
    } st_t;

    st_t  st_d, st_q;
    logic hit;

    always_comb begin
        st_d      = st_q;
        hit       = fall_sel_i ? (st_q.prev & ~sig_i) : (sig_i & ~st_q.prev);
        st_d.prev = sig_i;
        // a detected edge takes priority over a software clear
        st_d.flag = hit | (st_q.flag & ~clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;

    // R9
    rise_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall_sel_i && sig_i && !st_q.prev) |=> flag_o);
    // R9 R11
    fall_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_sel_i && !sig_i && st_q.prev) |=> flag_o);
    // R10
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);
    // R10
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !hit) |=> !flag_o);
endmodule

// File: rtl/sysctl_keyreg.sv
module sysctl_keyreg #(
    parameter int unsigned          W     = 9,
    parameter int unsigned          KW    = 8,
    parameter logic [W-1:0]         RST   = '0,
    parameter logic [KW-1:0]        CODE  = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic [KW-1:0] key_i,
    input  logic [W-1:0]  data_i,
    output logic [W-1:0]  q_o
);
    logic [W-1:0] val_d, val_q;
    logic         unlocked;

    always_comb begin
        unlocked = (key_i == CODE);
        val_d    = val_q;
        if (wr_i && unlocked) val_d = data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= RST;
        else        val_q <= val_d;
    end

    assign q_o = val_q;

    // R3
    key_ok_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && key_i == CODE) |=> (q_o == $past(data_i)));
    // R4
    key_bad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && key_i != CODE) |=> $stable(q_o));
endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
    import sysctl_pkg::*;
#(
    parameter int unsigned ADDR_W      = 12,
    parameter logic [15:0] MOD_ID      = 16'h6B4E,
    parameter logic [3:0]  STD_OFF     = 4'h0,
    parameter logic [3:0]  INST_IDX    = 4'h0,
    parameter logic [3:0]  REV_MAJ     = 4'h1,
    parameter logic [3:0]  REV_MIN     = 4'h0,
    parameter logic [31:0] DEV_ID      = 32'h0BB8_402F,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              cmp_async_i,
    output logic [8:0]        atest_sw_o,
    output logic [1:0]        tsens_sel_o,
    output logic              tsens_on_o,
    output logic              cmp_event_o,
    output logic              cmp_wake_o
);
    localparam logic [ADDR_W-1:0] A_IDENT = ADDR_W'(OFF_IDENT);
    localparam logic [ADDR_W-1:0] A_ATEST = ADDR_W'(OFF_ATEST);
    localparam logic [ADDR_W-1:0] A_SENS  = ADDR_W'(OFF_SENS);
    localparam logic [ADDR_W-1:0] A_CMP   = ADDR_W'(OFF_CMP);
    localparam logic [ADDR_W-1:0] A_DEVID = ADDR_W'(OFF_DEVID);
    localparam logic [ADDR_W-1:0] A_PART  = ADDR_W'(OFF_PART);
    localparam logic [31:0] IDENT_VAL = {MOD_ID, STD_OFF, INST_IDX, REV_MAJ, REV_MIN};
    localparam logic [31:0] DEVID_VAL = DEV_ID | 32'd1;

    bank_t  bank_d, bank_q;
    logic   hit_ident, hit_atest, hit_sens, hit_cmp, hit_devid, hit_part, any_hit;
    logic   cmp_lvl, evt_flag, flag_clr;
    logic [ATEST_W-1:0] atest_q;

    always_comb begin
        hit_ident = (bus_addr == A_IDENT);
        hit_atest = (bus_addr == A_ATEST);
        hit_sens  = (bus_addr == A_SENS);
        hit_cmp   = (bus_addr == A_CMP);
        hit_devid = (bus_addr == A_DEVID);
        hit_part  = (bus_addr == A_PART);
        any_hit   = hit_ident | hit_atest | hit_sens | hit_cmp | hit_devid | hit_part;
    end

    // unlock-gated analog-test word
    sysctl_keyreg #(
        .W    (ATEST_W),
        .KW   (KEY_W),
        .RST  (ATEST_RST),
        .CODE (UNLOCK_CODE)
    ) u_atest (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (bus_wr & hit_atest),
        .key_i  (bus_wdata[31:32-KEY_W]),
        .data_i (bus_wdata[ATEST_W-1:0]),
        .q_o    (atest_q)
    );

    sysctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (cmp_async_i),
        .sync_o  (cmp_lvl)
    );

    always_comb flag_clr = bus_wr & hit_cmp & ~bus_wdata[CMP_FLAG_BIT];

    sysctl_evtflag u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .sig_i      (cmp_lvl),
        .fall_sel_i (bank_q.cmp_cfg[CMP_FALL_BIT]),
        .clr_i      (flag_clr),
        .flag_o     (evt_flag)
    );

    // next-state for the plain read/write words
    always_comb begin
        bank_d = bank_q;
        if (bus_wr && hit_sens) begin
            bank_d.sens_sel   = bus_wdata[1:0];
            bank_d.sens_spare = bus_wdata[11:8];
        end
        if (bus_wr && hit_cmp)  bank_d.cmp_cfg = bus_wdata & CMP_RW_MASK;
        if (bus_wr && hit_part) bank_d.part_id = bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    // read return
    always_comb begin
        bus_rdata = '0;
        if (hit_ident) bus_rdata = IDENT_VAL;
        if (hit_atest) bus_rdata = {{(32-ATEST_W){1'b0}}, atest_q};
        if (hit_sens)  bus_rdata = {20'd0, bank_q.sens_spare, 6'd0, bank_q.sens_sel};
        if (hit_cmp) begin
            bus_rdata = bank_q.cmp_cfg;
            bus_rdata[CMP_FLAG_BIT] = evt_flag;
            bus_rdata[CMP_LVL_BIT]  = cmp_lvl;
        end
        if (hit_devid) bus_rdata = DEVID_VAL;
        if (hit_part)  bus_rdata = bank_q.part_id;
    end

    assign atest_sw_o  = atest_q;
    assign tsens_sel_o = bank_q.sens_sel;
    assign tsens_on_o  = (bank_q.sens_sel != SENS_OFF_CODE);
    assign cmp_event_o = bank_q.cmp_cfg[CMP_EVEN_BIT] & evt_flag;
    assign cmp_wake_o  = bank_q.cmp_cfg[CMP_WAKE_BIT] & cmp_lvl;

    // R13
    part_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit_part) |=> (bank_q.part_id == $past(bus_wdata)));
    // R14
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !any_hit) |=> (bank_q == $past(bank_q)));
    // R7
    cmp_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_q.cmp_cfg & ~CMP_RW_MASK) == 32'd0);
endmodule

// File: tb/sim_sysctl_regbank.sv
module sim_sysctl_regbank;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] bus_addr;
    logic        bus_wr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        cmp_in;
    logic [8:0]  atest_sw_o;
    logic [1:0]  tsens_sel_o;
    logic        tsens_on_o, cmp_event_o, cmp_wake_o;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    // bench model
    logic [8:0]  at_m;
    logic [1:0]  sel_m;
    logic [3:0]  spare_m;
    logic [31:0] cmp_m, part_m;
    logic        flag_m, lvl_m;

    always #10 clk = ~clk;

    sysctl_regbank u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_async_i(cmp_in),
        .atest_sw_o(atest_sw_o), .tsens_sel_o(tsens_sel_o), .tsens_on_o(tsens_on_o),
        .cmp_event_o(cmp_event_o), .cmp_wake_o(cmp_wake_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [11:0] a);
        case (a)
            12'h000: return 32'h6B4E_0010;
            12'h100: return {23'd0, at_m};
            12'h108: return {20'd0, spare_m, 6'd0, sel_m};
            12'h10C: return cmp_m | (32'(flag_m) << 24) | (32'(lvl_m) << 20);
            12'h3FC: return 32'h0BB8_402F;
            12'h7F8: return part_m;
            default: return 32'd0;
        endcase
    endfunction

    function automatic void model_wr(input logic [11:0] a, input logic [31:0] d);
        case (a)
            12'h100: if (d[31:24] == 8'h5A) at_m = d[8:0];
            12'h108: begin sel_m = d[1:0]; spare_m = d[11:8]; end
            12'h10C: begin cmp_m = d & 32'h7027_7FFF; if (!d[24]) flag_m = 1'b0; end
            12'h7F8: part_m = d;
            default: ;
        endcase
    endfunction

    // called at a falling edge; returns at the next falling edge
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
        model_wr(a, d);
    endtask

    task automatic rd(input string req, input logic [11:0] a);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp_rd(a));
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic summary;
        if (!done) begin
            done = 1;
            $display("  Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++; nchk++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [11:0] map [6] = '{12'h000, 12'h100, 12'h108, 12'h10C, 12'h3FC, 12'h7F8};
        void'($urandom(32'd20240607));
        rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; cmp_in = 1'b0;
        at_m = 9'h00F; sel_m = 0; spare_m = 0; cmp_m = 0; part_m = 0; flag_m = 0; lvl_m = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state: R1 R2 R13
        rd("R1 ident", 12'h000);
        rd("R2 atest reset", 12'h100);
        rd("R2 sens reset", 12'h108);
        rd("R2 cmp reset", 12'h10C);
        rd("R2 part reset", 12'h7F8);
        rd("R13 devid", 12'h3FC);
        chk("R2 atest_sw_o reset", 32'(atest_sw_o), 32'h00F);
        chk("R2 event reset", 32'(cmp_event_o), 32'd0);

        // key-gated writes: R3 R4 R5
        wr(12'h100, 32'h5A00_01F0);
        rd("R3 unlocked write", 12'h100);
        chk("R3 atest_sw_o", 32'(atest_sw_o), 32'h1F0);
        wr(12'h100, 32'h5B00_0003);
        rd("R4 wrong key ignored", 12'h100);
        chk("R4 atest_sw_o held", 32'(atest_sw_o), 32'h1F0);
        wr(12'h100, 32'h0000_0000);
        chk("R4 zero key held", 32'(atest_sw_o), 32'h1F0);
        wr(12'h100, 32'h5AFF_FFFF);
        rd("R5 key and reserved read zero", 12'h100);
        chk("R5 value", bus_rdata, 32'h0000_01FF);

        // sensor word: R6
        wr(12'h108, 32'hFFFF_FFFF);
        chk("R6 sens mask", bus_rdata, 32'h0000_0F03);
        chk("R6 sensor off at 3", 32'(tsens_on_o), 32'd0);
        wr(12'h108, 32'h0000_0002);
        rd("R6 sens write", 12'h108);
        chk("R6 sensor on", 32'(tsens_on_o), 32'd1);
        chk("R6 select out", 32'(tsens_sel_o), 32'd2);

        // comparator mask: R7
        wr(12'h10C, 32'hFEFF_FFFF);
        rd("R7 cmp mask", 12'h10C);
        chk("R7 value", bus_rdata, 32'h7027_7FFF);
        wr(12'h10C, 32'h0000_0000);

        // read-only words and part id: R1 R13
        wr(12'h000, 32'hFFFF_FFFF);
        rd("R1 ident write ignored", 12'h000);
        wr(12'h3FC, 32'h0000_0000);
        rd("R13 devid write ignored", 12'h3FC);
        wr(12'h7F8, 32'hA5C3_0F96);
        rd("R13 part write", 12'h7F8);

        // unmapped: R14
        wr(12'h104, 32'hFFFF_FFFF);
        rd("R14 unmapped read", 12'h104);
        for (int i = 0; i < 6; i++) rd("R14 mapped unchanged", map[i]);

        // constrained random: R3 R4 R6 R7 R13 R14
        for (int n = 0; n < 400; n++) begin
            int unsigned pick = $urandom % 8;
            logic [11:0] a = (pick < 6) ? map[pick] : 12'(($urandom % 1024) * 4);
            logic [31:0] d = $urandom;
            if (a == 12'h100 && ($urandom % 2) == 1) d[31:24] = 8'h5A;
            wr(a, d);
            rd("R14 random read-back", a);
            rd("R13 random other read", map[$urandom % 6]);
            chk("R3 R4 random atest_sw_o", 32'(atest_sw_o), 32'(at_m));
            chk("R6 random sensor on", 32'(tsens_on_o), 32'(sel_m != 2'd3));
        end

        // comparator: rising polarity, event and wake enabled
        wr(12'h10C, 32'h0006_0001);
        cmp_in = 1'b1;
        cyc(1);
        rd("R8 level not yet visible", 12'h10C);
        cyc(1);
        lvl_m = 1'b1;
        rd("R8 level after two stages", 12'h10C);
        chk("R12 wake follows level", 32'(cmp_wake_o), 32'd1);
        chk("R9 flag not before third edge", 32'(bus_rdata[24]), 32'd0);
        cyc(1);
        flag_m = 1'b1;
        rd("R9 rising edge sets flag", 12'h10C);
        chk("R12 event raised", 32'(cmp_event_o), 32'd1);

        // sticky and clear: R10
        wr(12'h10C, 32'h0106_0001);
        rd("R10 write one keeps flag", 12'h10C);
        cyc(3);
        rd("R10 flag sticky", 12'h10C);
        wr(12'h10C, 32'h0006_0001);
        rd("R10 write zero clears", 12'h10C);
        chk("R12 event drops", 32'(cmp_event_o), 32'd0);

        // falling edge with rising polarity: R9
        cmp_in = 1'b0;
        cyc(4);
        lvl_m = 1'b0;
        rd("R9 wrong direction ignored", 12'h10C);
        chk("R12 wake off at low level", 32'(cmp_wake_o), 32'd0);

        // falling polarity, event disabled
        wr(12'h10C, 32'h0001_0001);
        cmp_in = 1'b1;
        cyc(4);
        lvl_m = 1'b1;
        rd("R9 rise ignored when falling chosen", 12'h10C);
        // edge and clear in the same cycle: R11
        cmp_in = 1'b0;
        cyc(2);
        wr(12'h10C, 32'h0001_0001);
        lvl_m = 1'b0;
        flag_m = 1'b1;
        rd("R11 set wins over clear", 12'h10C);
        chk("R12 event gated off", 32'(cmp_event_o), 32'd0);
        wr(12'h10C, 32'h0103_0001);
        chk("R12 event enabled", 32'(cmp_event_o), 32'd1);
        wr(12'h10C, 32'h0003_0001);
        rd("R10 final clear", 12'h10C);
        chk("R12 event final", 32'(cmp_event_o), 32'd0);

        summary();
    end
endmodule